// File: doc/BRIEF.md
# Oversampling Serial Receiver

This block takes an asynchronous serial line and turns each character on it into a parallel word. An internal prescaler divides the system clock into a sampling tick running at sixteen times the baud rate. The input passes through a two-flop synchroniser before any decision is made. A falling edge arms the receiver. The low level must then hold until the middle of the start bit; a shorter dip counts as noise, and the receiver goes back to idle. After that, each data, parity and stop bit is sampled once, at its centre, sixteen ticks after the previous sample.

The frame format comes from static configuration inputs that the paired transmitter also uses:
- a data length of 5 to 9 bits;
- parity on or off, with odd or even sense;
- one or two stop bits.

Each completed character is presented right-aligned with a valid strobe and three error flags. It stays there until the consumer pulses the read acknowledge. A character that completes while the previous one is still unread is discarded, and an overrun is reported against the held one.

Top module: `serial_rx`

## Requirements
- R1: After reset, `rx_valid`, `err_frame`, `err_parity`, `err_overrun` and `rx_data` are all zero.
- R2: A start is accepted only if the synchronised line is low at the tick where the falling edge is detected and stays low for the next 8 ticks. A low pulse shorter than half a bit produces no character.
- R3: Data bits arrive least significant first. `cfg_len` gives their count: 5 to 9 are used as given, values below 5 act as 5 and values above 9 act as 9. The word is right-aligned in `rx_data` with the unused upper bits zero.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `err_parity` is set when the XOR of the data bits and the parity bit is 1 under even parity (`cfg_par_odd`=0), or 0 under odd parity (`cfg_par_odd`=1). When parity is off, no parity bit is expected and `err_parity` is 0.
- R5: Stop bits are one bit, or two when `cfg_stop2`=1. `err_frame` is set for the character if any stop bit is sampled low.
- R6: `rx_valid` rises when a character completes and stays high until a one-cycle `rd_ack`. Data and flags are stable while it is high. `rd_ack` clears `rx_valid` and `err_overrun`.
- R7: If a character completes while `rx_valid` is high and `rd_ack` is not asserted, the held word and its error flags are kept, and `err_overrun` is set.
- R8: After a framing error, the receiver starts no new character until the line has been seen high.
- R9: Frames sent back to back with no idle gap are each received, resynchronising on every start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | 4 | Data bits per character (5..9) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits, 0 = one |
| rd_ack | input | 1 | One-cycle pulse: the held character has been read |
| rx_data | output | 9 | Received word, right-aligned |
| rx_valid | output | 1 | A received character is held |
| err_frame | output | 1 | Stop bit sampled low for the held character |
| err_parity | output | 1 | Parity mismatch for the held character |
| err_overrun | output | 1 | A later character was lost while this one was unread |

## Verification
The bench sends low pulses of five and six ticks. A receiver without the start confirmation would turn these into spurious all-zero characters.

It also stresses the points where a wrong implementation still looks plausible:
- Short and nine-bit lengths: a misaligned shifter would return the word shifted or with stray upper bits.
- Parity, forced right and wrong under both senses: an inverted sense would flag every clean character.
- A bad second stop bit: a receiver checking only the first would miss it.
- Two unread characters in a row: a receiver that overwrites would show the second byte instead of the first.

After a framing error the line is held low for more than a frame. A receiver that re-armed at once would report a phantom character.

// File: rtl/serial_rx.sv
module serial_rx #(
  parameter int TICK_DIV = 4,
  parameter int MAX_BITS = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_in,
  input  logic [$clog2(MAX_BITS+1)-1:0] cfg_len,
  input  logic                        cfg_par_en,
  input  logic                        cfg_par_odd,
  input  logic                        cfg_stop2,
  input  logic                        rd_ack,
  output logic [MAX_BITS-1:0]         rx_data,
  output logic                        rx_valid,
  output logic                        err_frame,
  output logic                        err_parity,
  output logic                        err_overrun
);
  localparam int LW = $clog2(MAX_BITS+1);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MIN_BITS = 5;
  localparam logic [3:0] CONFIRM = 4'd7;
  localparam logic [3:0] CENTRE = 4'd15;

  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP, HOLD} st_t;

  logic s1, s2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rx_in;
      s2 <= s1;
    end

  logic [PW-1:0] pc;
  logic tick;
  assign tick = (pc == PW'(TICK_DIV-1));
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pc <= '0;
    else pc <= tick ? '0 : pc + 1'b1;

  st_t st;
  logic [3:0] sub;
  logic [LW-1:0] bitn;
  logic [MAX_BITS-1:0] sh;
  logic par_acc, fr_acc;
  logic [LW-1:0] eff_len;
  logic mid, last_stop, done, fr_now, par_bad;
  logic [MAX_BITS-1:0] word;

  always_comb begin
    if (cfg_len < LW'(MIN_BITS)) eff_len = LW'(MIN_BITS);
    else if (cfg_len > LW'(MAX_BITS)) eff_len = LW'(MAX_BITS);
    else eff_len = cfg_len;
  end

  assign mid       = tick && (sub == CENTRE);
  assign last_stop = cfg_stop2 ? (bitn == LW'(1)) : (bitn == '0);
  assign done      = (st == STOP) && mid && last_stop;
  assign fr_now    = fr_acc | ~s2;
  assign par_bad   = cfg_par_en & (par_acc ^ cfg_par_odd);
  assign word      = sh >> (LW'(MAX_BITS) - eff_len);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE;
      sub <= '0;
      bitn <= '0;
      sh <= '0;
      par_acc <= 1'b0;
      fr_acc <= 1'b0;
    end else if (tick) begin
      case (st)
        IDLE:
          if (!s2) begin
            st <= START;
            sub <= '0;
          end
        START:
          if (s2) st <= IDLE;
          else if (sub == CONFIRM) begin
            st <= DATA;
            sub <= '0;
            bitn <= '0;
            sh <= '0;
            par_acc <= 1'b0;
            fr_acc <= 1'b0;
          end else sub <= sub + 1'b1;
        DATA: begin
          sub <= sub + 1'b1;
          if (sub == CENTRE) begin
            sh <= {s2, sh[MAX_BITS-1:1]};
            par_acc <= par_acc ^ s2;
            if (bitn == eff_len - 1'b1) begin
              bitn <= '0;
              st <= cfg_par_en ? PAR : STOP;
            end else bitn <= bitn + 1'b1;
          end
        end
        PAR: begin
          sub <= sub + 1'b1;
          if (sub == CENTRE) begin
            par_acc <= par_acc ^ s2;
            st <= STOP;
          end
        end
        STOP: begin
          sub <= sub + 1'b1;
          if (sub == CENTRE) begin
            fr_acc <= fr_now;
            if (last_stop) st <= fr_now ? HOLD : IDLE;
            else bitn <= bitn + 1'b1;
          end
        end
        HOLD:
          if (s2) st <= IDLE;
        default: st <= IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0;
      rx_valid <= 1'b0;
      err_frame <= 1'b0;
      err_parity <= 1'b0;
      err_overrun <= 1'b0;
    end else if (done) begin
      if (rx_valid && !rd_ack) err_overrun <= 1'b1;
      else begin
        rx_data <= word;
        rx_valid <= 1'b1;
        err_frame <= fr_now;
        err_parity <= par_bad;
        err_overrun <= 1'b0;
      end
    end else if (rd_ack) begin
      rx_valid <= 1'b0;
      err_overrun <= 1'b0;
    end

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rd_ack) |=> rx_valid);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !done) |=> (!rx_valid && !err_overrun));
  // R7
  overrun_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rd_ack && done) |=> (err_overrun && $stable(rx_data) && $stable(err_frame)));
  // R2
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == START && tick && s2) |=> (st == IDLE));
  // R8
  hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HOLD && !s2) |=> (st == HOLD));
  // R4
  par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_par_en && !(rx_valid && !rd_ack)) |=> !err_parity);
endmodule

// File: tb/sim_serial_rx.sv
module sim_serial_rx;
  localparam int BIT = 64;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic [3:0] cfg_len = 4'd8;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0;
  logic rd_ack = 1'b0;
  logic [8:0] rx_data;
  logic rx_valid, err_frame, err_parity, err_overrun;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_rx u0 (.clk, .rst_n, .rx_in, .cfg_len, .cfg_par_en, .cfg_par_odd,
                .cfg_stop2, .rd_ack, .rx_data, .rx_valid, .err_frame,
                .err_parity, .err_overrun);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int clocks);
    rx_in = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] d, input int n, input bit bad_par,
                      input bit bad_stop1, input bit bad_stop2);
    logic p;
    p = cfg_par_odd;
    hold_line(1'b0, BIT);
    for (int i = 0; i < n; i++) begin
      hold_line(d[i], BIT);
      p = p ^ d[i];
    end
    if (cfg_par_en) hold_line(p ^ bad_par, BIT);
    hold_line(!bad_stop1, BIT);
    if (cfg_stop2) hold_line(!bad_stop2, BIT);
  endtask

  task automatic ack();
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_char(input string req, input logic [8:0] d, input int fe, input int pe);
    hold_line(1'b1, BIT/2);
    check({req, " valid"}, rx_valid, 1);
    check({req, " data"}, rx_data, d);
    check({req, " frame"}, err_frame, fe);
    check({req, " parity"}, err_parity, pe);
    ack();
    check({req, " ack clears"}, rx_valid, 0);
  endtask

  task automatic t_reset();
    check("R1 valid", rx_valid, 0);
    check("R1 data", rx_data, 0);
    check("R1 flags", {err_frame, err_parity, err_overrun}, 0);
  endtask

  task automatic t_basic();
    cfg_len = 8; cfg_par_en = 0; cfg_stop2 = 0;
    send(9'h0A5, 8, 0, 0, 0);
    expect_char("R3 8N1 A5", 9'h0A5, 0, 0);
    send(9'h03C, 8, 0, 0, 0);
    expect_char("R4 no parity 3C", 9'h03C, 0, 0);
  endtask

  task automatic t_lengths();
    cfg_len = 5;
    send(9'h016, 5, 0, 0, 0);
    expect_char("R3 len5", 9'h016, 0, 0);
    cfg_len = 9;
    send(9'h1C3, 9, 0, 0, 0);
    expect_char("R3 len9", 9'h1C3, 0, 0);
    cfg_len = 3;
    send(9'h013, 5, 0, 0, 0);
    expect_char("R3 len clamp low", 9'h013, 0, 0);
    cfg_len = 8;
  endtask

  task automatic t_parity();
    cfg_par_en = 1; cfg_par_odd = 0; cfg_len = 7;
    send(9'h05B, 7, 0, 0, 0);
    expect_char("R4 even good", 9'h05B, 0, 0);
    send(9'h05B, 7, 1, 0, 0);
    expect_char("R4 even bad", 9'h05B, 0, 1);
    cfg_par_odd = 1; cfg_len = 8;
    send(9'h0F0, 8, 0, 0, 0);
    expect_char("R4 odd good", 9'h0F0, 0, 0);
    send(9'h0F1, 8, 1, 0, 0);
    expect_char("R4 odd bad", 9'h0F1, 0, 1);
    cfg_par_en = 0; cfg_par_odd = 0;
  endtask

  task automatic t_stop();
    cfg_stop2 = 1;
    send(9'h081, 8, 0, 0, 0);
    expect_char("R5 two stops good", 9'h081, 0, 0);
    send(9'h07E, 8, 0, 0, 1);
    expect_char("R5 second stop low", 9'h07E, 1, 0);
    cfg_stop2 = 0;
  endtask

  task automatic t_hold();
    send(9'h055, 8, 0, 1, 0);
    hold_line(1'b0, BIT/2);
    check("R5 frame err valid", rx_valid, 1);
    check("R5 frame err flag", err_frame, 1);
    check("R5 frame err data", rx_data, 9'h055);
    ack();
    hold_line(1'b0, 12*BIT);
    check("R8 no char while low", rx_valid, 0);
    hold_line(1'b1, 2*BIT);
    check("R8 no char after release", rx_valid, 0);
    send(9'h0C3, 8, 0, 0, 0);
    expect_char("R8 recovers", 9'h0C3, 0, 0);
  endtask

  task automatic t_glitch();
    hold_line(1'b0, 5*4);
    hold_line(1'b1, 12*BIT);
    check("R2 glitch 5 ticks", rx_valid, 0);
    hold_line(1'b0, 6*4);
    hold_line(1'b1, 12*BIT);
    check("R2 glitch 6 ticks", rx_valid, 0);
    send(9'h099, 8, 0, 0, 0);
    expect_char("R2 real start after glitch", 9'h099, 0, 0);
  endtask

  task automatic t_overrun();
    send(9'h011, 8, 0, 0, 0);
    send(9'h0EE, 8, 0, 0, 0);
    hold_line(1'b1, BIT/2);
    check("R7 valid", rx_valid, 1);
    check("R7 old byte kept", rx_data, 9'h011);
    check("R7 overrun flag", err_overrun, 1);
    check("R9 back to back clean", err_frame, 0);
    ack();
    check("R6 ack clears overrun", err_overrun, 0);
    check("R6 ack clears valid", rx_valid, 0);
  endtask

  task automatic t_hold_valid();
    send(9'h042, 8, 0, 0, 0);
    hold_line(1'b1, 4*BIT);
    check("R6 held until ack", rx_valid, 1);
    check("R6 data stable", rx_data, 9'h042);
    ack();
    check("R6 cleared", rx_valid, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_lengths();
    t_parity();
    t_stop();
    t_hold();
    t_glitch();
    t_overrun();
    t_hold_valid();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end
endmodule